// File: doc/BRIEF.md
# Line Power-Loss Detector

This block decides when AC mains has gone away. It looks at a one-bit flag from an external comparator stage. The flag is high while the line voltage sits within a narrow band around the supply rail. A live AC line only crosses that band briefly at each zero crossing. A dead line stays inside it. The block measures how long the flag stays high, counting ticks of a slow free-running time base. It declares a loss only when the flag stays high through a set number of those ticks. Because the tick phase against the moment of entry is arbitrary, the detection delay lies inside a bounded window. With the default two ticks of about 1.95 ms, that window is about 2 to 4 ms, which is longer than any dwell a healthy 60 Hz line produces.

On a loss, the block latches a status bit and raises an interrupt request. Software reads the status bit and clears it with a one-cycle pulse. Software can also poll the window flag path again to see whether power has returned. Detection runs only while the enable input is high.

The design is a small state machine with four states. It is fed by a two-flop synchronizer and drives a sticky status latch. The states are:

- OFF: detection disabled.
- LIVE: line healthy, flag low.
- DWELL: flag high, ticks being counted.
- LOST: loss declared, waiting for the flag to drop.

The transitions are:

- OFF to LIVE: when enabled.
- LIVE to DWELL: when the synchronized flag rises.
- DWELL to LIVE: when the flag falls.
- DWELL to LOST: on the final tick.
- LOST to LIVE: when the flag falls.
- Any state to OFF: when the enable drops.

Top module: `line_loss_detector`

## Requirements
- R1: While `sense_en` is low, no tick and no window level sets `loss_stat`.
- R2: `win_raw` passes through a two-flop synchronizer. A tick sampled on any of the first three rising edges after `win_raw` rises is not counted toward the dwell.
- R3: With the default TRIP_TICKS of 2, `loss_stat` goes high on the same rising edge that samples the second tick of a continuous dwell. It is not set by the first tick.
- R4: `irq` is high exactly while `loss_stat` is high.
- R5: When the synchronized window flag goes low, the tick count is discarded. A later dwell needs the full TRIP_TICKS ticks again.
- R6: Repeated short dwells, each spanning fewer than TRIP_TICKS ticks, never set `loss_stat`.
- R7: Once set, `loss_stat` stays high until a `stat_clr` pulse. The bit reads low from the following rising edge on.
- R8: Dropping `sense_en` discards a partial dwell count. It leaves an already-set `loss_stat` unchanged.
- R9: When a loss is declared on the same edge as a `stat_clr` pulse, `loss_stat` ends up set.
- R10: After reset, `loss_stat` and `irq` are low.
- R11: A single continuous dwell declares at most one loss. After a clear while still inside the window, further ticks do not set `loss_stat` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse of the slow time base |
| win_raw | input | 1 | Asynchronous comparator flag, high while line is near the rail |
| sense_en | input | 1 | Detection enable |
| stat_clr | input | 1 | One-cycle read-and-clear pulse for the status bit |
| loss_stat | output | 1 | Latched power-loss status |
| irq | output | 1 | Interrupt request, high while status is set |

## Verification
The assertions assume three things about the inputs. `tick` and `stat_clr` are single-cycle pulses that are synchronous to `clk`. `sense_en` changes only between edges. `win_raw` may change at any time, because it is synchronized. The stimulus drives every input just after a falling edge and holds `tick` and `stat_clr` for one cycle. The only exception is the synchronizer scenario, which holds `tick` on purpose across the edges where the flag is still in flight. Each dwell is entered and left with enough idle cycles to cover the synchronizer latency, so every scenario starts from a settled LIVE state.

// File: rtl/lld_pkg.sv
package lld_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LIVE  = 2'd1,
        ST_DWELL = 2'd2,
        ST_LOST  = 2'd3
    } lld_state_e;

endpackage

// File: rtl/lld_sync.sv
module lld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/lld_dwell_fsm.sv
module lld_dwell_fsm
    import lld_pkg::*;
#(
    parameter int TRIP_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic win_s,
    input  logic tick,
    output logic fire
);

    localparam int CW = (TRIP_TICKS < 2) ? 1 : $clog2(TRIP_TICKS);
    localparam logic [CW-1:0] LAST = CW'(TRIP_TICKS - 1);

    lld_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic last_tick;

    assign last_tick = tick && (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        unique case (state_q)
            ST_OFF: begin
                if (en) state_d = ST_LIVE;
            end
            ST_LIVE: begin
                if (!en)       state_d = ST_OFF;
                else if (win_s) state_d = ST_DWELL;
            end
            ST_DWELL: begin
                if (!en)             state_d = ST_OFF;
                else if (!win_s)     state_d = ST_LIVE;
                else if (last_tick)  state_d = ST_LOST;
                else if (tick)       cnt_d   = cnt_q + 1'b1;
                else                 cnt_d   = cnt_q;
            end
            ST_LOST: begin
                if (!en)         state_d = ST_OFF;
                else if (!win_s) state_d = ST_LIVE;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_DWELL: fire = en && win_s && last_tick;
            ST_OFF, ST_LIVE, ST_LOST: fire = 1'b0;
            default: fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/lld_status.sv
module lld_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic stat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stat_o <= 1'b0;
        else if (set_i) stat_o <= 1'b1;
        else if (clr_i) stat_o <= 1'b0;
    end

endmodule

// File: rtl/line_loss_detector.sv
module line_loss_detector #(
    parameter int TRIP_TICKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic win_raw,
    input  logic sense_en,
    input  logic stat_clr,
    output logic loss_stat,
    output logic irq
);

    logic win_s;
    logic fire;

    lld_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (win_raw),
        .q_sync  (win_s)
    );

    lld_dwell_fsm #(.TRIP_TICKS(TRIP_TICKS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sense_en),
        .win_s (win_s),
        .tick  (tick),
        .fire  (fire)
    );

    lld_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fire),
        .clr_i  (stat_clr),
        .stat_o (loss_stat)
    );

    assign irq = loss_stat;

endmodule

// File: rtl/lld_chk.sv
module lld_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic sense_en,
    input logic stat_clr,
    input logic win_s,
    input logic loss_stat
);

    // R1
    no_set_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_en |=> !$rose(loss_stat));

    // R3
    set_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss_stat) |-> $past(tick));

    // R5
    no_set_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_s |=> !$rose(loss_stat));

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loss_stat && !stat_clr) |=> loss_stat);

    // R7
    clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !tick) |=> !loss_stat);

endmodule

bind line_loss_detector lld_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .sense_en  (sense_en),
    .stat_clr  (stat_clr),
    .win_s     (win_s),
    .loss_stat (loss_stat)
);

// File: tb/tb_line_loss_detector.sv
module tb_line_loss_detector;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, tick, win_raw, sense_en, stat_clr;
    logic loss_stat, irq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_loss_detector dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .win_raw(win_raw),
        .sense_en(sense_en), .stat_clr(stat_clr),
        .loss_stat(loss_stat), .irq(irq)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    task automatic pulse_clr();
        stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic enter_win();
        win_raw = 1'b1; cyc(4);
    endtask

    task automatic leave_win();
        win_raw = 1'b0; cyc(4);
    endtask

    task automatic t_reset();
        chk("R10 status after reset", loss_stat, 1'b0);
        chk("R10 irq after reset", irq, 1'b0);
    endtask

    task automatic t_trip();
        enter_win();
        pulse_tick();
        chk("R3 no trip on first tick", loss_stat, 1'b0);
        pulse_tick();
        chk("R3 trip on second tick", loss_stat, 1'b1);
        chk("R4 irq with status", irq, 1'b1);
        leave_win();
        pulse_tick(); pulse_tick();
        chk("R7 status sticky after window exit", loss_stat, 1'b1);
        pulse_clr();
        chk("R7 status cleared", loss_stat, 1'b0);
        chk("R4 irq falls with status", irq, 1'b0);
    endtask

    task automatic t_count_clear();
        enter_win();
        pulse_tick();
        leave_win();
        enter_win();
        pulse_tick();
        chk("R5 count discarded on window exit", loss_stat, 1'b0);
        pulse_tick();
        chk("R5 full count trips", loss_stat, 1'b1);
        leave_win(); pulse_clr();
    endtask

    task automatic t_ac_pattern();
        for (int i = 0; i < 8; i++) begin
            enter_win();
            pulse_tick();
            leave_win();
            cyc(3);
        end
        chk("R6 short dwells never trip", loss_stat, 1'b0);
        chk("R6 irq quiet on healthy line", irq, 1'b0);
    endtask

    task automatic t_sync();
        win_raw = 1'b1; tick = 1'b1;
        cyc(3);
        tick = 1'b0;
        cyc(1);
        pulse_tick();
        chk("R2 early ticks not counted", loss_stat, 1'b0);
        pulse_tick();
        chk("R2 trip after two counted ticks", loss_stat, 1'b1);
        leave_win(); pulse_clr();
    endtask

    task automatic t_enable();
        sense_en = 1'b0;
        cyc(2);
        enter_win();
        for (int i = 0; i < 4; i++) pulse_tick();
        chk("R1 disabled never trips", loss_stat, 1'b0);
        sense_en = 1'b1; cyc(3);
        pulse_tick();
        sense_en = 1'b0; cyc(3);
        sense_en = 1'b1; cyc(3);
        pulse_tick();
        chk("R8 disable discards count", loss_stat, 1'b0);
        pulse_tick();
        chk("R8 trip after fresh count", loss_stat, 1'b1);
        sense_en = 1'b0; cyc(3);
        chk("R8 status kept when disabled", loss_stat, 1'b1);
        sense_en = 1'b1;
        leave_win(); pulse_clr();
    endtask

    task automatic t_set_wins();
        enter_win();
        pulse_tick();
        tick = 1'b1; stat_clr = 1'b1;
        @(negedge clk);
        tick = 1'b0; stat_clr = 1'b0;
        chk("R9 set beats clear", loss_stat, 1'b1);
        pulse_clr();
        for (int i = 0; i < 4; i++) pulse_tick();
        chk("R11 one loss per dwell", loss_stat, 1'b0);
        leave_win();
    endtask

    initial begin
        rst_n = 1'b0; tick = 1'b0; win_raw = 1'b0;
        sense_en = 1'b1; stat_clr = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_trip();
        t_count_clear();
        t_ac_pattern();
        t_sync();
        t_enable();
        t_set_wins();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule